// File: doc/BRIEF.md
# Split-Request Address Parity Generator and Checker

This block protects a bus request that travels in two halves. In the first half the shared request lines carry the address. In the second half they carry transaction-type information. Two parity bits guard the lines. The set of lines that each parity bit covers is exchanged between the two halves of the same request. All bus lines are treated as active-low wires.

The initiator side computes the parity pair for whatever the lines hold in a strobed cycle and launches it from a register. The receiver side computes the same parity on its own and compares it with the parity bits it receives. It raises one error flag for each parity bit, with a separate pair of flags for each half of the request. Cycles without the request strobe are never checked and never produce parity.

Top module: `reqpar_unit`

## Requirements
- R1: A parity bit is 1 when an even number of the lines it covers are 0, and 0 when an odd number of them are 0.
- R2: When every line that a parity bit covers is 1, that parity bit is 1.
- R3: In the first half (`subphase2` = 0), bit 0 covers `addr_n[32:21]` (address lines 35:24). Bit 1 covers `addr_n[20:0]` (address lines 23:3) together with all of `req_n[4:0]`.
- R4: In the second half (`subphase2` = 1), the coverage is exchanged. Bit 1 covers `addr_n[32:21]`. Bit 0 covers `addr_n[20:0]` together with `req_n[4:0]`.
- R5: After a clock edge at which `strobe_n` = 0, `par_out_n` holds the parity pair for the lines sampled at that edge. After an edge at which `strobe_n` = 1, `par_out_n` is 2'b11.
- R6: After a clock edge at which `strobe_n` = 0, bit k of the flag pair for the current half is 1 exactly when `par_in_n[k]` differs from the recomputed parity bit k. `err_sp1` serves the first half and `err_sp2` the second.
- R7: After an edge at which `strobe_n` = 1, both flag pairs are 0, whatever `par_in_n` holds.
- R8: While `rst_n` = 0 at a clock edge, the block afterwards shows `par_out_n` = 2'b11 and both flag pairs at 0.
- R9: The flag pair of the half that was not presented is 0, so `err_sp1` and `err_sp2` are never nonzero together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_n | input | 33 | Active-low address lines; bit i is address line i+3 |
| req_n | input | 5 | Active-low request-type lines |
| subphase2 | input | 1 | 0 = first half of the request, 1 = second half |
| strobe_n | input | 1 | Request-valid strobe, active low |
| par_in_n | input | 2 | Received parity pair |
| par_out_n | output | 2 | Generated parity pair, registered |
| err_sp1 | output | 2 | Per-bit mismatch flags for the first half |
| err_sp2 | output | 2 | Per-bit mismatch flags for the second half |

## Verification
Each result is due exactly one clock edge after its stimulus is sampled. The generated pair and both flag pairs come from a single register stage, and they fall back to their idle values one edge after an unstrobed cycle. The bench drives every stimulus on a falling edge. It then waits for the next falling edge, so exactly one rising edge lies in between, and it checks all three outputs there against parity that it counts itself from the lines. The sweeps walk a single low line across all 38 lines in both halves, inject every mismatch mask, and run a long pseudo-random series, so each result is compared in the cycle it is due and not later.

// File: rtl/reqpar_pkg.sv
// Shared sizes and types for the split-request parity block.
// Assumes the address word is indexed from line 3 upward and that the
// upper coverage group sits at the top of that word.
package reqpar_pkg;
    localparam int ADDR_LINES  = 33;   // address lines 35:3
    localparam int REQ_LINES   = 5;    // request-type lines
    localparam int UPPER_LINES = 12;   // address lines 35:24
    localparam int PAR_BITS    = 2;    // parity bits per request half

    typedef logic [PAR_BITS-1:0] par_pair_t;

    // Idle level of an active-low parity pair.
    localparam par_pair_t PAR_IDLE = '1;
endpackage

// File: rtl/reqpar_group_parity.sv
// Parity of one coverage group of active-low lines.
// Output is 1 when the number of lines at 0 is even, including the case
// where no line is low. Purely combinational.
module reqpar_group_parity #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] lines_n,
    output logic             par_n
);
    // Count low lines modulo two, then invert so that an even count gives 1.
    always_comb begin
        par_n = ~(^(~lines_n));
    end
endmodule

// File: rtl/reqpar_core.sv
// Combinational parity pair for one request half.
// Splits the lines into an upper address group and a lower group (low
// address lines plus request lines). The half indicator then decides which
// parity bit carries which group. Used separately by initiator and receiver.
module reqpar_core
    import reqpar_pkg::*;
#(
    parameter int ADDR_W  = ADDR_LINES,
    parameter int REQ_W   = REQ_LINES,
    parameter int UPPER_W = UPPER_LINES
) (
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic              subphase2,
    output par_pair_t         par_n
);
    localparam int LOWER_W = ADDR_W - UPPER_W;
    localparam int LOWGRP_W = LOWER_W + REQ_W;

    logic                upper_par_n;
    logic                lower_par_n;
    logic [LOWGRP_W-1:0] lower_lines_n;

    // Gather the lower coverage group.
    always_comb begin
        lower_lines_n = {addr_n[LOWER_W-1:0], req_n};
    end

    reqpar_group_parity #(.WIDTH(UPPER_W)) u_upper (
        .lines_n (addr_n[ADDR_W-1:LOWER_W]),
        .par_n   (upper_par_n)
    );

    reqpar_group_parity #(.WIDTH(LOWGRP_W)) u_lower (
        .lines_n (lower_lines_n),
        .par_n   (lower_par_n)
    );

    // Route the two group parities onto the pair; the coverage is exchanged in the second half.
    for (genvar k = 0; k < PAR_BITS; k++) begin : g_route
        localparam bit UPPER_IN_FIRST = (k == 0);
        always_comb begin
            if (subphase2 ^ UPPER_IN_FIRST)
                par_n[k] = upper_par_n;
            else
                par_n[k] = lower_par_n;
        end
    end
endmodule

// File: rtl/reqpar_gen.sv
// Initiator-side generator. Registers the parity pair for a strobed cycle.
// Assumes strobe_n is active low and sampled on the same edge as the lines.
// Idle or reset drives the pair to its high (inactive) level.
module reqpar_gen
    import reqpar_pkg::*;
#(
    parameter int ADDR_W  = ADDR_LINES,
    parameter int REQ_W   = REQ_LINES,
    parameter int UPPER_W = UPPER_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic              subphase2,
    input  logic              strobe_n,
    output par_pair_t         par_out_n
);
    par_pair_t calc_n;

    reqpar_core #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .UPPER_W(UPPER_W)) u_core (
        .addr_n    (addr_n),
        .req_n     (req_n),
        .subphase2 (subphase2),
        .par_n     (calc_n)
    );

    // Launch register: computed pair on a strobed cycle, idle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            par_out_n <= PAR_IDLE;
        else if (!strobe_n)
            par_out_n <= calc_n;
        else
            par_out_n <= PAR_IDLE;
    end
endmodule

// File: rtl/reqpar_chk.sv
// Receiver-side checker. Recomputes parity and compares it with the received
// pair in strobed cycles. Flags are single-cycle, split by request half and
// valid one edge after the data was presented.
module reqpar_chk
    import reqpar_pkg::*;
#(
    parameter int ADDR_W  = ADDR_LINES,
    parameter int REQ_W   = REQ_LINES,
    parameter int UPPER_W = UPPER_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic              subphase2,
    input  logic              strobe_n,
    input  par_pair_t         par_in_n,
    output par_pair_t         err_sp1,
    output par_pair_t         err_sp2
);
    par_pair_t expect_n;
    par_pair_t mismatch;

    reqpar_core #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .UPPER_W(UPPER_W)) u_core (
        .addr_n    (addr_n),
        .req_n     (req_n),
        .subphase2 (subphase2),
        .par_n     (expect_n)
    );

    // Per-bit disagreement between the received and recomputed pairs.
    always_comb begin
        mismatch = expect_n ^ par_in_n;
    end

    // First-half flags: set only in strobed first-half cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_sp1 <= '0;
        else if (!strobe_n && !subphase2)
            err_sp1 <= mismatch;
        else
            err_sp1 <= '0;
    end

    // Second-half flags: set only in strobed second-half cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_sp2 <= '0;
        else if (!strobe_n && subphase2)
            err_sp2 <= mismatch;
        else
            err_sp2 <= '0;
    end
endmodule

// File: rtl/reqpar_unit.sv
// Top of the split-request parity block: an initiator-side generator and a
// receiver-side checker, each with its own parity tree. Both sample the same
// lines. Assumes synchronous active-low reset and active-low bus lines.
module reqpar_unit
    import reqpar_pkg::*;
#(
    parameter int ADDR_W  = ADDR_LINES,
    parameter int REQ_W   = REQ_LINES,
    parameter int UPPER_W = UPPER_LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_n,
    input  logic [REQ_W-1:0]  req_n,
    input  logic              subphase2,
    input  logic              strobe_n,
    input  logic [1:0]        par_in_n,
    output logic [1:0]        par_out_n,
    output logic [1:0]        err_sp1,
    output logic [1:0]        err_sp2
);
    reqpar_gen #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .UPPER_W(UPPER_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_n    (addr_n),
        .req_n     (req_n),
        .subphase2 (subphase2),
        .strobe_n  (strobe_n),
        .par_out_n (par_out_n)
    );

    reqpar_chk #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .UPPER_W(UPPER_W)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_n    (addr_n),
        .req_n     (req_n),
        .subphase2 (subphase2),
        .strobe_n  (strobe_n),
        .par_in_n  (par_in_n),
        .err_sp1   (err_sp1),
        .err_sp2   (err_sp2)
    );
endmodule

// File: rtl/reqpar_unit_props.sv
// Assertion checker for reqpar_unit, attached through bind. It relates the
// generator's launched pair to the checker's flags and to the port timing.
module reqpar_unit_props #(
    parameter int ADDR_W  = 33,
    parameter int REQ_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_n,
    input logic [REQ_W-1:0]  req_n,
    input logic              subphase2,
    input logic              strobe_n,
    input logic [1:0]        par_in_n,
    input logic [1:0]        par_out_n,
    input logic [1:0]        err_sp1,
    input logic [1:0]        err_sp2
);
    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (par_out_n == 2'b11 && err_sp1 == 2'b00 && err_sp2 == 2'b00));

    // R7
    no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> (err_sp1 == 2'b00 && err_sp2 == 2'b00));

    // R5
    gen_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |=> (par_out_n == 2'b11));

    // R2
    all_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && (&addr_n) && (&req_n)) |=> (par_out_n == 2'b11));

    // R6
    first_half_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !subphase2) |=> (err_sp1 == (par_out_n ^ $past(par_in_n))));

    // R6
    second_half_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && subphase2) |=> (err_sp2 == (par_out_n ^ $past(par_in_n))));

    // R9
    one_half_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|err_sp1) && (|err_sp2)));
endmodule

bind reqpar_unit reqpar_unit_props #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_n    (addr_n),
    .req_n     (req_n),
    .subphase2 (subphase2),
    .strobe_n  (strobe_n),
    .par_in_n  (par_in_n),
    .par_out_n (par_out_n),
    .err_sp1   (err_sp1),
    .err_sp2   (err_sp2)
);

// File: tb/reqpar_unit_test.sv
`timescale 1ns/1ps
module reqpar_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [32:0] addr_n = '1;
    logic [4:0]  req_n = '1;
    logic        subphase2 = 1'b0;
    logic        strobe_n = 1'b1;
    logic [1:0]  par_in_n = 2'b11;
    logic [1:0]  par_out_n;
    logic [1:0]  err_sp1;
    logic [1:0]  err_sp2;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    reqpar_unit uut (
        .clk(clk), .rst_n(rst_n), .addr_n(addr_n), .req_n(req_n),
        .subphase2(subphase2), .strobe_n(strobe_n), .par_in_n(par_in_n),
        .par_out_n(par_out_n), .err_sp1(err_sp1), .err_sp2(err_sp2)
    );

    // Expected pair from counted low lines (R1, R3, R4): {bit1, bit0}.
    function automatic logic [1:0] exp_par(input logic [32:0] a, input logic [4:0] r, input logic s2);
        int hi = 0;
        int lo = 0;
        logic ph, pl;
        for (int i = 21; i < 33; i++) if (!a[i]) hi++;
        for (int i = 0; i < 21; i++) if (!a[i]) lo++;
        for (int i = 0; i < 5; i++) if (!r[i]) lo++;
        ph = (hi % 2 == 0);
        pl = (lo % 2 == 0);
        return s2 ? {ph, pl} : {pl, ph};
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, check all outputs one rising edge later.
    task automatic step(input string tag, input logic [32:0] a, input logic [4:0] r,
                        input logic s2, input logic stb_n, input logic [1:0] flip);
        logic [1:0] good;
        good = exp_par(a, r, s2);
        @(negedge clk);
        addr_n = a; req_n = r; subphase2 = s2; strobe_n = stb_n;
        par_in_n = good ^ flip;
        @(negedge clk);
        check({tag, " par_out_n (R5)"}, par_out_n, stb_n ? 2'b11 : good);
        check({tag, " err_sp1 (R6/R7/R9)"}, err_sp1, (!stb_n && !s2) ? flip : 2'b00);
        check({tag, " err_sp2 (R6/R7/R9)"}, err_sp2, (!stb_n && s2) ? flip : 2'b00);
    endtask

    initial begin
        // R8: reset with strobe and wrong parity presented
        rst_n = 1'b0; strobe_n = 1'b0; addr_n = '0; par_in_n = 2'b00;
        repeat (3) @(negedge clk);
        check("R8 par_out_n", par_out_n, 2'b11);
        check("R8 err_sp1", err_sp1, 2'b00);
        check("R8 err_sp2", err_sp2, 2'b00);
        rst_n = 1'b1; strobe_n = 1'b1; addr_n = '1;

        // R2: all lines high gives high parity in both halves
        step("R2 first", '1, '1, 1'b0, 1'b0, 2'b00);
        step("R2 second", '1, '1, 1'b1, 1'b0, 2'b00);

        // R1/R3/R4: walk one low line across all 38 lines in both halves
        for (int s = 0; s < 2; s++) begin
            for (int j = 0; j < 38; j++) begin
                logic [37:0] v = ~(38'd1 << j);
                step(s == 0 ? "R3 walk" : "R4 walk", v[37:5], v[4:0], s[0], 1'b0, 2'b00);
            end
        end

        // R3/R4: two lows in one group keep that group's parity high
        step("R1 pair upper", ~(33'h3 << 21), '1, 1'b0, 1'b0, 2'b00);
        step("R1 pair mixed", ~33'h1, 5'b11110, 1'b1, 1'b0, 2'b00);

        // R6: every mismatch mask in both halves
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 4; m++) begin
                step("R6 inject", {1'b0, 32'hA5C3_0F17}, 5'b10110, s[0], 1'b0, m[1:0]);
            end
        end

        // R7: no strobe, wrong parity presented, flags stay low and pair idle
        for (int m = 0; m < 4; m++) begin
            step("R7 idle", 33'h0_0000_0000, 5'b00000, m[0], 1'b1, m[1:0] | 2'b01);
        end

        // Pseudo-random series mixing halves, strobes and masks
        for (int n = 0; n < 400; n++) begin
            logic [32:0] a;
            logic [4:0]  r;
            rng = next_rng(rng); a[31:0] = rng;
            rng = next_rng(rng); a[32] = rng[0]; r = rng[5:1];
            step("R1 random", a, r, rng[6], rng[7] & rng[8], rng[10:9]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule